// File: doc/BRIEF.md
# Serial Programming Command Slave

This block is the target-side end of a serial programming port. A programmer acting as master drives a serial clock, a data line and an active-low select, using clock mode 0. The block runs entirely on the target's own system clock: it oversamples the serial pins through synchronizers and finds clock edges in that domain. From the incoming bit stream it forms bytes, most significant bit first. It then checks that each frame opens with the two marker bytes AAh and 55h, captures a command byte and a 16-bit address, and passes the bytes that follow to a memory back end as a stream. For each byte slot it also asks the back end for a byte to shift out.

The serial output is only driven once the programmer has completed an unlock exchange in the current programming session. That exchange is command ACh with key byte 53h, and the block echoes 53h while the last header byte is clocked. An active-low session input marks the programming session, and raising it forgets the unlock. The serial output comes out as a data bit plus an output-enable, so that the pad cell can tristate it.

Both data streams are paced entirely by the master's serial clock, so neither can be held back. The write stream (`wr_valid_o`) is a one-cycle strobe, and the back end must accept it in that cycle. The read stream is a request (`rd_req_o`): `rd_data_i` must hold the byte for `rd_addr_o` during the same system clock cycle in which the request is high. The system clock must run at least four times faster than the serial clock.

Top module: `prog_cmd_slave`

## Requirements
- R1: Incoming bits are taken on rising serial-clock edges and gathered most significant bit first. The outgoing bit changes only on falling serial-clock edges, and each returned byte also leaves most significant bit first.
- R2: While select is high, serial clock and data are ignored, the output-enable is low, and the bit count and frame progress return to the start state. A partial byte is therefore discarded.
- R3: The first byte of a frame must be AAh and the second 55h. On any mismatch, the block ignores the rest of that frame until select rises and raises no command, write or read strobe.
- R4: In an accepted frame, the third byte is the command and the fourth and fifth bytes are the address, high byte first. Once the fifth byte is complete, `cmd_valid_o` pulses for one cycle, with `cmd_op_o` and `cmd_addr_o` holding the captured values.
- R5: Each byte after the address produces one `wr_valid_o` pulse, carrying the byte and its address. The address starts at the captured value. After each byte the low log2(PAGE_BYTES) bits advance by one, wrapping to the start of the same page; the upper bits stay fixed.
- R6: One system clock after the last rising edge of the address-low byte and of every data byte, `rd_req_o` pulses with the address of the next byte slot. The `rd_data_i` value sampled in that cycle is shifted out during the next byte.
- R7: A frame with command ACh and address-high 53h unlocks the port. The block returns 53h during the address-low byte and does not raise `cmd_valid_o` for this frame.
- R8: Until the port is unlocked, the output-enable stays low. Any frame whose command is not ACh then produces no command, write or read strobe.
- R9: While `sess_n_i` is high, the unlock is cleared and the serial pins are ignored. A new unlock is needed after the session input returns low.
- R10: `frame_end_o` pulses for one cycle on each rising edge of select during a session.
- R11: The output-enable is high only while the port is unlocked and selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_n_i | input | 1 | Active-low programming-session input |
| sck_i | input | 1 | Serial clock from master |
| mosi_i | input | 1 | Serial data from master |
| sel_n_i | input | 1 | Active-low select from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output-enable for the serial data pad |
| cmd_valid_o | output | 1 | Header complete strobe |
| cmd_op_o | output | 8 | Captured command byte |
| cmd_addr_o | output | 16 | Captured address |
| wr_valid_o | output | 1 | Incoming data byte strobe |
| wr_data_o | output | 8 | Incoming data byte |
| wr_addr_o | output | 16 | Address of incoming data byte |
| rd_req_o | output | 1 | Request for the next outgoing byte |
| rd_addr_o | output | 16 | Address of the requested byte |
| rd_data_i | input | 8 | Outgoing byte, valid while rd_req_o is high |
| frame_end_o | output | 1 | Select-rise strobe |

## Verification
The bench builds the block with its default values: 8-bit bytes, a 64-byte page and two synchronizer stages, with the serial clock at one eighth of the system clock. With a 64-byte page, a write starting at address 013Eh crosses the page end within three bytes, so the wrap back to 0100h can be observed. The eightfold oversampling leaves room for the read request to be answered and loaded before the first falling edge of the next byte. It also makes it possible to check that a partial byte left behind by a deselect is dropped.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    PH_MARK0,
    PH_MARK1,
    PH_OPC,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_SKIP
  } phase_e;

  localparam logic [7:0] MARK0_BYTE  = 8'hAA;
  localparam logic [7:0] MARK1_BYTE  = 8'h55;
  localparam logic [7:0] UNLOCK_OPC  = 8'hAC;
  localparam logic [7:0] UNLOCK_KEY  = 8'h53;
endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= st[s-1];
      end
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/pcs_bitlink.sv
module pcs_bitlink #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          sel_n_s,
  input  logic          load_en,
  input  logic [DW-1:0] load_data,
  output logic          byte_stb,
  output logic [DW-1:0] byte_val,
  output logic          miso_bit
);
  localparam int CNT_W = $clog2(DW);

  logic             sck_d;
  logic [CNT_W-1:0] bitcnt;
  logic [DW-2:0]    rx_q;
  logic [DW-1:0]    tx_q;
  logic             rise, fall;

  assign rise = !sel_n_s && sck_s && !sck_d;
  assign fall = !sel_n_s && !sck_s && sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      rx_q   <= '0;
    end else if (sel_n_s) begin
      bitcnt <= '0;
      rx_q   <= '0;
    end else if (rise) begin
      bitcnt <= bitcnt + CNT_W'(1);
      rx_q   <= {rx_q[DW-3:0], mosi_s};
    end
  end

  assign byte_stb = rise && (bitcnt == CNT_W'(DW - 1));
  assign byte_val = {rx_q, mosi_s};

  // The falling edge that closes the last bit of a byte must not shift,
  // so a byte loaded after that byte keeps its top bit on the line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tx_q <= '0;
    else if (sel_n_s)                 tx_q <= '0;
    else if (load_en)                 tx_q <= load_data;
    else if (fall && bitcnt != '0)    tx_q <= {tx_q[DW-2:0], 1'b0};
  end

  assign miso_bit = tx_q[DW-1];

  a_r1_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(miso_bit) && !sel_n_s && !$past(sel_n_s) && !$past(load_en)) |-> $past(fall));

  a_r2_idle_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> (bitcnt == '0));
endmodule

// File: rtl/pcs_framer.sv
module pcs_framer
  import pcs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int PAGE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sess_act,
  input  logic          sel_n_s,
  input  logic          byte_stb,
  input  logic [DW-1:0] byte_val,
  input  logic [DW-1:0] rd_data_i,
  output logic          enabled_o,
  output logic          load_en,
  output logic [DW-1:0] load_data,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_op_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          frame_end_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int HI_W  = AW - DW;

  phase_e        phase;
  logic          sel_d;
  logic          echo_ld;
  logic [HI_W-1:0] addr_hi;
  logic [AW-1:0] ptr_q, ptr_nxt;

  assign ptr_nxt = {ptr_q[AW-1:OFS_W], ptr_q[OFS_W-1:0] + OFS_W'(1)};

  assign load_en   = rd_req_o || echo_ld;
  assign load_data = echo_ld ? UNLOCK_KEY : rd_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_MARK0;
      sel_d       <= 1'b1;
      echo_ld     <= 1'b0;
      enabled_o   <= 1'b0;
      addr_hi     <= '0;
      ptr_q       <= '0;
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= '0;
      cmd_addr_o  <= '0;
      wr_valid_o  <= 1'b0;
      wr_data_o   <= '0;
      wr_addr_o   <= '0;
      rd_req_o    <= 1'b0;
      rd_addr_o   <= '0;
      frame_end_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      wr_valid_o  <= 1'b0;
      rd_req_o    <= 1'b0;
      echo_ld     <= 1'b0;
      sel_d       <= sel_n_s;
      frame_end_o <= sel_n_s && !sel_d && sess_act;
      if (!sess_act) enabled_o <= 1'b0;

      if (sel_n_s) begin
        phase <= PH_MARK0;
      end else if (byte_stb) begin
        unique case (phase)
          PH_MARK0: phase <= (byte_val == MARK0_BYTE) ? PH_MARK1 : PH_SKIP;
          PH_MARK1: phase <= (byte_val == MARK1_BYTE) ? PH_OPC : PH_SKIP;
          PH_OPC: begin
            cmd_op_o <= byte_val;
            phase    <= (enabled_o || byte_val == UNLOCK_OPC) ? PH_AHI : PH_SKIP;
          end
          PH_AHI: begin
            addr_hi <= byte_val;
            if (cmd_op_o == UNLOCK_OPC) begin
              if (byte_val == UNLOCK_KEY) begin
                enabled_o <= 1'b1;
                echo_ld   <= 1'b1;
              end
              phase <= PH_SKIP;
            end else begin
              phase <= PH_ALO;
            end
          end
          PH_ALO: begin
            cmd_addr_o  <= {addr_hi, byte_val};
            ptr_q       <= {addr_hi, byte_val};
            rd_addr_o   <= {addr_hi, byte_val};
            cmd_valid_o <= 1'b1;
            rd_req_o    <= 1'b1;
            phase       <= PH_DATA;
          end
          PH_DATA: begin
            wr_valid_o <= 1'b1;
            wr_data_o  <= byte_val;
            wr_addr_o  <= ptr_q;
            ptr_q      <= ptr_nxt;
            rd_req_o   <= 1'b1;
            rd_addr_o  <= ptr_nxt;
          end
          default: phase <= PH_SKIP;
        endcase
      end
    end
  end

  a_r8_cmd_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> enabled_o);

  a_r9_session_clears_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_act |=> !enabled_o);

  a_r3_skip_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |=> (!cmd_valid_o && !wr_valid_o));

  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_addr_o[AW-1:OFS_W] == cmd_addr_o[AW-1:OFS_W]));

  a_r10_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, wr_valid_o, frame_end_o, echo_ld}));
endmodule

// File: rtl/prog_cmd_slave.sv
module prog_cmd_slave #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int PAGE_BYTES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sess_n_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          sel_n_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_op_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          frame_end_o
);
  logic [3:0]    pins_s;
  logic          sck_s, mosi_s, sel_raw_s, sess_act, sel_eff_n;
  logic          byte_stb, miso_bit, enabled, load_en;
  logic [DW-1:0] byte_val, load_data;

  pcs_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sess_n_i, sel_n_i, mosi_i, sck_i}),
    .q_o(pins_s)
  );

  assign sck_s     = pins_s[0];
  assign mosi_s    = pins_s[1];
  assign sel_raw_s = pins_s[2];
  assign sess_act  = !pins_s[3];
  assign sel_eff_n = sel_raw_s || !sess_act;

  pcs_bitlink #(.DW(DW)) u_link (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sck_s), .mosi_s(mosi_s), .sel_n_s(sel_eff_n),
    .load_en(load_en), .load_data(load_data),
    .byte_stb(byte_stb), .byte_val(byte_val), .miso_bit(miso_bit)
  );

  pcs_framer #(.DW(DW), .AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .sess_act(sess_act), .sel_n_s(sel_eff_n),
    .byte_stb(byte_stb), .byte_val(byte_val), .rd_data_i(rd_data_i),
    .enabled_o(enabled), .load_en(load_en), .load_data(load_data),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_addr_o(wr_addr_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .frame_end_o(frame_end_o)
  );

  assign miso_o    = miso_bit;
  assign miso_oe_o = enabled && !sel_eff_n;

  a_r11_oe_off_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !$past(enabled)) |-> !miso_oe_o);

  a_r2_rd_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_eff_n && $past(sel_eff_n)) |-> (!rd_req_o && !wr_valid_o && !cmd_valid_o));
endmodule

// File: tb/test_prog_cmd_slave.sv
module test_prog_cmd_slave;
  logic        clk = 1'b0;
  logic        rst_n, sess_n, sck, mosi, sel_n;
  logic        miso, miso_oe, cmd_valid, wr_valid, rd_req, frame_end;
  logic [7:0]  cmd_op, wr_data, rd_data;
  logic [15:0] cmd_addr, wr_addr, rd_addr;

  always #10 clk = ~clk;

  prog_cmd_slave i_prog_cmd_slave (
    .clk(clk), .rst_n(rst_n), .sess_n_i(sess_n),
    .sck_i(sck), .mosi_i(mosi), .sel_n_i(sel_n),
    .miso_o(miso), .miso_oe_o(miso_oe),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_addr_o(cmd_addr),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .wr_addr_o(wr_addr),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .frame_end_o(frame_end)
  );

  // Back-end model: byte at an address is its low byte xor 5Ah.
  assign rd_data = rd_addr[7:0] ^ 8'h5A;

  int checks = 0, fails = 0;
  int cmd_cnt = 0, wr_cnt = 0, rd_cnt = 0, fe_cnt = 0;
  bit oe_seen = 0, done = 0;
  logic [7:0]  last_op;
  logic [15:0] last_addr;
  logic [7:0]  wlog_d [32];
  logic [15:0] wlog_a [32];
  logic [7:0]  txb [16];
  logic [7:0]  rxb [16];

  always @(negedge clk) begin
    if (cmd_valid) begin cmd_cnt++; last_op = cmd_op; last_addr = cmd_addr; end
    if (wr_valid) begin wlog_d[wr_cnt % 32] = wr_data; wlog_a[wr_cnt % 32] = wr_addr; wr_cnt++; end
    if (rd_req) rd_cnt++;
    if (frame_end) fe_cnt++;
    if (miso_oe) oe_seen = 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int n);
    sel_n = 1'b0;
    half();
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = txb[i][b];
        half();
        rxb[i][b] = miso_oe ? miso : 1'b0;
        sck = 1'b1;
        half();
        sck = 1'b0;
      end
    end
    half();
    sel_n = 1'b1;
    half();
    half();
  endtask

  task automatic set5(input logic [7:0] a, b, c, d, e);
    txb[0] = a; txb[1] = b; txb[2] = c; txb[3] = d; txb[4] = e;
  endtask

  task automatic t_reset();
    chk(miso_oe == 1'b0, "R11", "oe after reset", miso_oe, 0);
    chk(cmd_cnt == 0 && wr_cnt == 0 && rd_cnt == 0, "R2", "strobes after reset", cmd_cnt + wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_locked();
    int c0 = cmd_cnt, r0 = rd_cnt;
    oe_seen = 0;
    set5(8'hAA, 8'h55, 8'h30, 8'h12, 8'h34); txb[5] = 8'hFF;
    send_frame(6);
    chk(cmd_cnt == c0, "R8", "cmd while locked", cmd_cnt - c0, 0);
    chk(rd_cnt == r0, "R8", "rd while locked", rd_cnt - r0, 0);
    chk(oe_seen == 0, "R8", "oe while locked", oe_seen, 0);
  endtask

  task automatic t_unlock();
    int c0 = cmd_cnt, f0 = fe_cnt;
    set5(8'hAA, 8'h55, 8'hAC, 8'h53, 8'h00);
    send_frame(5);
    chk(rxb[4] == 8'h53, "R7", "unlock echo", rxb[4], 8'h53);
    chk(cmd_cnt == c0, "R7", "no cmd for unlock", cmd_cnt - c0, 0);
    chk(fe_cnt == f0 + 1, "R10", "frame end count", fe_cnt - f0, 1);
    chk(miso_oe == 1'b0, "R11", "oe when deselected", miso_oe, 0);
  endtask

  task automatic t_bad_marker();
    int c0 = cmd_cnt, w0 = wr_cnt, r0 = rd_cnt;
    set5(8'hAA, 8'h54, 8'h50, 8'h00, 8'h00); txb[5] = 8'h11; txb[6] = 8'h22;
    send_frame(7);
    set5(8'hAB, 8'h55, 8'h50, 8'h00, 8'h00);
    send_frame(7);
    chk(cmd_cnt == c0, "R3", "cmd on bad marker", cmd_cnt - c0, 0);
    chk(wr_cnt == w0 && rd_cnt == r0, "R3", "data strobes on bad marker", wr_cnt - w0 + rd_cnt - r0, 0);
  endtask

  task automatic t_write_wrap();
    int c0 = cmd_cnt, w0 = wr_cnt;
    set5(8'hAA, 8'h55, 8'h50, 8'h01, 8'h3E); txb[5] = 8'h11; txb[6] = 8'h22; txb[7] = 8'h33;
    send_frame(8);
    chk(cmd_cnt == c0 + 1, "R4", "cmd count", cmd_cnt - c0, 1);
    chk(last_op == 8'h50, "R4", "opcode", last_op, 8'h50);
    chk(last_addr == 16'h013E, "R4", "address", last_addr, 16'h013E);
    chk(wr_cnt == w0 + 3, "R5", "write count", wr_cnt - w0, 3);
    chk(wlog_d[w0 % 32] == 8'h11 && wlog_a[w0 % 32] == 16'h013E, "R5", "byte0 addr", wlog_a[w0 % 32], 16'h013E);
    chk(wlog_d[(w0 + 1) % 32] == 8'h22 && wlog_a[(w0 + 1) % 32] == 16'h013F, "R5", "byte1 addr", wlog_a[(w0 + 1) % 32], 16'h013F);
    chk(wlog_d[(w0 + 2) % 32] == 8'h33 && wlog_a[(w0 + 2) % 32] == 16'h0100, "R5", "wrap addr", wlog_a[(w0 + 2) % 32], 16'h0100);
  endtask

  task automatic t_read();
    int r0 = rd_cnt;
    set5(8'hAA, 8'h55, 8'h30, 8'h02, 8'h05); txb[5] = 8'h00; txb[6] = 8'h00;
    send_frame(7);
    chk(rxb[5] == 8'h5F, "R6", "read byte0", rxb[5], 8'h5F);
    chk(rxb[6] == 8'h5C, "R1", "read byte1 msb first", rxb[6], 8'h5C);
    chk(rd_cnt == r0 + 3, "R6", "read request count", rd_cnt - r0, 3);
    chk(rxb[3] == 8'h00, "R1", "header idle out", rxb[3], 0);
  endtask

  task automatic t_deselect();
    int c0 = cmd_cnt, w0 = wr_cnt, r0 = rd_cnt;
    oe_seen = 0;
    for (int i = 0; i < 16; i++) begin
      mosi = i[0]; half(); sck = 1'b1; half(); sck = 1'b0;
    end
    chk(cmd_cnt == c0 && wr_cnt == w0 && rd_cnt == r0, "R2", "strobes while deselected", cmd_cnt - c0 + wr_cnt - w0, 0);
    chk(oe_seen == 0, "R11", "oe while deselected", oe_seen, 0);
    sel_n = 1'b0; half();
    for (int b = 0; b < 3; b++) begin
      mosi = 1'b1; half(); sck = 1'b1; half(); sck = 1'b0;
    end
    half(); sel_n = 1'b1; half(); half();
    set5(8'hAA, 8'h55, 8'h50, 8'h00, 8'h10); txb[5] = 8'h77;
    send_frame(6);
    chk(wr_cnt == w0 + 1 && wlog_d[w0 % 32] == 8'h77, "R2", "partial byte dropped", wlog_d[w0 % 32], 8'h77);
  endtask

  task automatic t_session_end();
    int c0;
    sess_n = 1'b1; half(); sess_n = 1'b0; half();
    oe_seen = 0;
    c0 = cmd_cnt;
    set5(8'hAA, 8'h55, 8'h30, 8'h00, 8'h00); txb[5] = 8'h00;
    send_frame(6);
    chk(cmd_cnt == c0, "R9", "cmd after session end", cmd_cnt - c0, 0);
    chk(oe_seen == 0, "R9", "oe after session end", oe_seen, 0);
    set5(8'hAA, 8'h55, 8'hAC, 8'h53, 8'h00);
    send_frame(5);
    chk(rxb[4] == 8'h53, "R9", "re-unlock echo", rxb[4], 8'h53);
  endtask

  initial begin
    rst_n = 1'b0; sess_n = 1'b0; sck = 1'b0; mosi = 1'b0; sel_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_bad_marker();
    t_write_wrap();
    t_read();
    t_deselect();
    t_session_end();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule